// File: doc/BRIEF.md
# Saturating Packed Add/Subtract Unit

This unit adds or subtracts two 32-bit signed operands. It can treat them as one full word or as two separate 16-bit lanes. Each operation either wraps in two's complement or clamps to the signed limit of its lane. The arithmetic path is combinational, so the result appears in the same cycle as the operands.

Any overflow raised by an issued operation sets a sticky flag at bit 20 of a 32-bit control register. Software can read that register at any time. Software can also overwrite it, and an overwrite is the only way to clear the flag. Overflow is detected differently for addition and for subtraction. On a saturating subtract, the clamp direction follows the minuend's sign, and a zero minuend counts as non-negative.

Top module: `psa_unit`

## Requirements
- R1: With `op_sub`=0 and `sat_en`=0 in word mode (`pair_mode`=0), `result` is `src_a + src_b` modulo 2^32. Overflow is raised exactly when both operands share a sign bit and the result's sign bit differs from `src_a`'s sign bit.
- R2: With `op_sub`=1 in word mode, `result` is `src_a - src_b`, and it wraps when `sat_en`=0. Overflow is raised exactly when the operand sign bits differ and the result's sign bit differs from `src_a`'s sign bit. For example, 0x80000000 - 0x80000000 gives 0 with no overflow, and 0x66666 - 0x55555 gives 0x11111 with no overflow.
- R3: A saturating add (`sat_en`=1) that overflows returns the positive limit when `src_a` is positive and the negative limit otherwise. In word mode the positive limit is 0x7FFFFFFF and the negative limit is 0x80000000.
- R4: A saturating subtract that overflows returns the positive limit when the minuend is zero or positive, and the negative limit otherwise. For example, 0 - 0x80000000 gives 0x7FFFFFFF.
- R5: With `pair_mode`=1, bits [15:0] and bits [31:16] are two independent signed lanes with no carry between them. Each lane detects its own overflow and saturates to 0x7FFF or 0x8000. For example, a subtract of 0x87658000 from 0x12340000 gives 0x7FFF7FFF.
- R6: A clock edge with `op_valid`=1 and an overflow sets bit 20 of the control register. This holds for a wrapping or a saturating operation, and for an overflow in either lane.
- R7: Once set, bit 20 stays set until a control write (`ctl_we`=1) loads it with 0.
- R8: `ctl_rdata` returns the register contents. The register resets to 0, and a write loads all 32 bits from `ctl_wdata`; the new value is visible after the edge.
- R9: An overflow on an edge with `op_valid`=0 leaves the register unchanged.
- R10: If a write and an overflowing operation share an edge, the register takes `ctl_wdata` with bit 20 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation issued this cycle (its overflow may set the flag) |
| op_sub | input | 1 | 0 = add, 1 = subtract (`src_a - src_b`) |
| pair_mode | input | 1 | 0 = one 32-bit word, 1 = two 16-bit lanes |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| src_a | input | 32 | First operand / minuend |
| src_b | input | 32 | Second operand / subtrahend |
| result | output | 32 | Combinational result |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register contents; bit 20 is the sticky overflow flag |

## Verification
`result` is combinational, so it is due in the same cycle as its operands. The bench drives inputs at a falling edge and samples `result` one nanosecond later. Any control register change comes from the next rising edge, so the bench compares `ctl_rdata` at the following falling edge, before it drives the next stimulus. A reference model in the bench updates the expected register contents at that point. The model takes the write data first and then ORs in the flag when the issued operation overflows.

// File: rtl/psa_pkg.sv
package psa_pkg;

    parameter int unsigned PSA_W     = 32;
    parameter int unsigned PSA_CTL_W = 32;
    parameter int unsigned PSA_FLAG  = 20;

    typedef enum logic {
        PSA_ADD = 1'b0,
        PSA_SUB = 1'b1
    } psa_op_e;

    typedef enum logic {
        PSA_WORD = 1'b0,
        PSA_PAIR = 1'b1
    } psa_mode_e;

    typedef struct packed {
        logic [PSA_W-1:0] value;
        logic             ovf;
    } psa_out_t;

    // Sign-bit overflow rule; differs between add and subtract.
    function automatic logic psa_ovf(input psa_op_e op, input logic a_msb,
                                     input logic b_msb, input logic r_msb);
        logic flipped;
        flipped = (r_msb != a_msb);
        if (op == PSA_ADD)
            return (a_msb == b_msb) && flipped;
        else
            return (a_msb != b_msb) && flipped;
    endfunction

endpackage

// File: rtl/psa_lane.sv
module psa_lane
    import psa_pkg::*;
#(
    parameter int unsigned LW = 16
) (
    input  psa_op_e        op,
    input  logic           sat,
    input  logic [LW-1:0]  a,
    input  logic [LW-1:0]  b,
    output logic [LW-1:0]  res,
    output logic           ovf
);
    localparam int unsigned MSB = LW - 1;
    localparam logic [LW-1:0] POS_LIM = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] NEG_LIM = {1'b1, {(LW-1){1'b0}}};

    logic [LW-1:0] raw;
    logic [LW-1:0] clamp;

    always_comb begin
        raw   = (op == PSA_SUB) ? (a - b) : (a + b);
        ovf   = psa_ovf(op, a[MSB], b[MSB], raw[MSB]);
        // On overflow the true result's sign follows operand a for both ops.
        clamp = a[MSB] ? NEG_LIM : POS_LIM;
        res   = (sat && ovf) ? clamp : raw;
    end
endmodule

// File: rtl/psa_ctl_reg.sv
module psa_ctl_reg #(
    parameter int unsigned CW       = 32,
    parameter int unsigned FLAG_BIT = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    input  logic          set_flag,
    output logic [CW-1:0] rdata
);
    logic [CW-1:0] ctl_q;
    logic [CW-1:0] ctl_d;

    always_comb begin
        ctl_d = we ? wdata : ctl_q;
        if (set_flag)
            ctl_d[FLAG_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    assign rdata = ctl_q;
endmodule

// File: rtl/psa_unit.sv
module psa_unit
    import psa_pkg::*;
#(
    parameter int unsigned W        = PSA_W,
    parameter int unsigned LANES    = 2,
    parameter int unsigned CW       = PSA_CTL_W,
    parameter int unsigned FLAG_BIT = PSA_FLAG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic          op_sub,
    input  logic          pair_mode,
    input  logic          sat_en,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    output logic [W-1:0]  result,
    input  logic          ctl_we,
    input  logic [CW-1:0] ctl_wdata,
    output logic [CW-1:0] ctl_rdata
);
    localparam int unsigned LW = W / LANES;

    psa_op_e   op;
    psa_mode_e mode;
    assign op   = psa_op_e'(op_sub);
    assign mode = psa_mode_e'(pair_mode);

    logic [W-1:0]     word_res;
    logic             word_ovf;
    logic [W-1:0]     pair_res;
    logic [LANES-1:0] lane_ovf;
    psa_out_t         sel;
    logic             ovf_any;

    psa_lane #(.LW(W)) i_word (
        .op (op), .sat(sat_en), .a(src_a), .b(src_b),
        .res(word_res), .ovf(word_ovf)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psa_lane #(.LW(LW)) i_lane (
            .op (op), .sat(sat_en),
            .a  (src_a[g*LW +: LW]), .b(src_b[g*LW +: LW]),
            .res(pair_res[g*LW +: LW]), .ovf(lane_ovf[g])
        );
    end

    always_comb begin
        if (mode == PSA_PAIR)
            sel = '{value: pair_res, ovf: |lane_ovf};
        else
            sel = '{value: word_res, ovf: word_ovf};
    end

    assign result  = sel.value;
    assign ovf_any = sel.ovf;

    psa_ctl_reg #(.CW(CW), .FLAG_BIT(FLAG_BIT)) i_ctl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
        .set_flag(op_valid & ovf_any), .rdata(ctl_rdata)
    );
endmodule

// File: rtl/psa_unit_chk.sv
module psa_unit_chk #(
    parameter int unsigned W        = 32,
    parameter int unsigned CW       = 32,
    parameter int unsigned FLAG_BIT = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic          pair_mode,
    input logic          sat_en,
    input logic [W-1:0]  result,
    input logic          ovf_any,
    input logic          ctl_we,
    input logic [CW-1:0] ctl_wdata,
    input logic [CW-1:0] ctl_rdata
);
    localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

    // R6 / R10: an issued overflow leaves the flag set after the edge
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ovf_any) |=> ctl_rdata[FLAG_BIT]);

    // R7: flag holds while no write occurs
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[FLAG_BIT] && !ctl_we) |=> ctl_rdata[FLAG_BIT]);

    // R9: without an issued overflow or write the flag does not rise
    a_r9_no_set: assert property (@(posedge clk) disable iff (rst)
        (!ctl_rdata[FLAG_BIT] && !ctl_we && !(op_valid && ovf_any))
        |=> !ctl_rdata[FLAG_BIT]);

    // R8: a write with no issued overflow loads the written value
    a_r8_write: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !(op_valid && ovf_any)) |=> (ctl_rdata == $past(ctl_wdata)));

    // R3 / R4: saturated word overflow lands on a limit
    a_r3_word_limit: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !pair_mode && ovf_any) |-> (result == WMAX || result == WMIN));
endmodule

bind psa_unit psa_unit_chk #(.W(W), .CW(CW), .FLAG_BIT(FLAG_BIT)) i_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .pair_mode(pair_mode),
    .sat_en(sat_en), .result(result), .ovf_any(ovf_any), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
);

// File: tb/test_psa_unit.sv
`timescale 1ns/1ps
module test_psa_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_sub, pair_mode, sat_en;
    logic [31:0] src_a, src_b, result;
    logic        ctl_we;
    logic [31:0] ctl_wdata, ctl_rdata;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_ctl = '0;

    always #5 clk = ~clk;

    psa_unit i_psa_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub),
        .pair_mode(pair_mode), .sat_en(sat_en), .src_a(src_a), .src_b(src_b),
        .result(result), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata)
    );

    function automatic logic [31:0] ref_lane(input logic [31:0] a, input logic [31:0] b,
                                             input int w, input bit sub, input bit sat,
                                             output bit ovf);
        longint sa, sb, r, mx, mn, msk;
        msk = (longint'(1) << w) - 1;
        sa = longint'(a) & msk;
        sb = longint'(b) & msk;
        if (sa >= (longint'(1) << (w - 1))) sa = sa - (longint'(1) << w);
        if (sb >= (longint'(1) << (w - 1))) sb = sb - (longint'(1) << w);
        r  = sub ? sa - sb : sa + sb;
        mx = (longint'(1) << (w - 1)) - 1;
        mn = -mx - 1;
        ovf = (r > mx) || (r < mn);
        if (ovf && sat) r = (r > mx) ? mx : mn;
        return 32'(r & msk);
    endfunction

    function automatic logic [31:0] ref_calc(input logic [31:0] a, input logic [31:0] b,
                                             input bit sub, input bit pair, input bit sat,
                                             output bit ovf);
        logic [31:0] lo, hi;
        bit o0, o1;
        if (pair) begin
            lo = ref_lane({16'h0, a[15:0]}, {16'h0, b[15:0]}, 16, sub, sat, o0);
            hi = ref_lane({16'h0, a[31:16]}, {16'h0, b[31:16]}, 16, sub, sat, o1);
            ovf = o0 | o1;
            return {hi[15:0], lo[15:0]};
        end
        lo = ref_lane(a, b, 32, sub, sat, o0);
        ovf = o0;
        return lo;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic check_ctl(input string tag);
        check(tag, ctl_rdata, exp_ctl);
    endtask

    // One operation (optionally with a control write on the same edge).
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input bit sub,
                         input bit pair, input bit sat, input bit valid,
                         input bit we, input logic [31:0] wd, input string ctl_tag);
        logic [31:0] er;
        bit eo;
        string tag;
        @(negedge clk);
        src_a = a; src_b = b; op_sub = sub; pair_mode = pair; sat_en = sat;
        op_valid = valid; ctl_we = we; ctl_wdata = wd;
        er = ref_calc(a, b, sub, pair, sat, eo);
        #1;
        if (pair)           tag = "R5";
        else if (sat && eo) tag = sub ? "R4" : "R3";
        else                tag = sub ? "R2" : "R1";
        check(tag, result, er);
        if (we) exp_ctl = wd;
        if (valid && eo) exp_ctl[20] = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; ctl_we = 1'b0;
        check_ctl(ctl_tag);
    endtask

    task automatic ctl_write(input logic [31:0] wd, input string tag);
        do_op(32'h1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, wd, tag);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        rst = 1'b1; op_valid = 0; op_sub = 0; pair_mode = 0; sat_en = 0;
        src_a = 0; src_b = 0; ctl_we = 0; ctl_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset", ctl_rdata, 32'h0);

        // Directed cases
        do_op(32'h12340000, 32'h87658000, 1, 1, 1, 1, 0, 0, "R6 pair sub");
        check("R5 example", result, 32'h7FFF7FFF);
        ctl_write(32'h0, "R7 clear");
        do_op(32'h0, 32'h80000000, 1, 0, 1, 1, 0, 0, "R6 word sub");
        check("R4 zero minuend", result, 32'h7FFFFFFF);
        ctl_write(32'h0, "R7 clear");
        do_op(32'h80000000, 32'h80000000, 1, 0, 1, 1, 0, 0, "R2 no flag");
        check("R2 equal", result, 32'h0);
        do_op(32'h00066666, 32'h00055555, 1, 0, 1, 1, 0, 0, "R2 no flag");
        check("R2 small", result, 32'h00011111);
        do_op(32'h7FFFFFFF, 32'h1, 0, 0, 0, 1, 0, 0, "R6 wrap add");
        check("R1 wrap", result, 32'h80000000);
        do_op(32'h1, 32'h1, 0, 0, 0, 1, 0, 0, "R7 held");
        ctl_write(32'hA5A5_0F0F, "R8 full write");
        ctl_write(32'h0, "R7 clear");
        do_op(32'h7FFF0000, 32'h00010000, 0, 1, 0, 1, 0, 0, "R6 upper lane");
        check("R5 lane wrap", result, 32'h80000000);
        ctl_write(32'h0, "R7 clear");
        do_op(32'h80000000, 32'h80000000, 0, 0, 1, 0, 0, 0, "R9 not issued");
        check("R3 neg", result, 32'h80000000);
        do_op(32'h80000000, 32'h1, 1, 0, 1, 1, 1, 32'h0000_1234, "R10 write+ovf");
        ctl_write(32'h0010_0000, "R8 set by write");
        ctl_write(32'h0, "R7 clear");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            int k;
            a = $urandom; b = $urandom;
            k = $urandom_range(0, 3);
            if (k == 0) a = {1'b0, a[30:0]} | 32'h7FF0_7FF0;
            if (k == 1) b = {1'b1, b[30:0]};
            do_op(a, b, 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom_range(0, 3) != 0), $urandom_range(0, 7) == 0,
                  $urandom, "R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule